// File: doc/BRIEF.md
# Serial EEPROM Command Front-End

This block is the slave side of a serial, word-organised nonvolatile memory model. It holds 256 words of 16 bits in flip-flops. A master selects the block, clocks in a start bit, a 2-bit opcode and an 8-bit address, and then either clocks in write data or clocks out read data. The protect-enable pin picks which command set the opcode belongs to: the memory commands or the commands for the protect register.

The serial pins are oversampled by a system clock `clk_i`, and every edge is detected against the previous sample. A command takes effect only when chip select falls after the command is complete, so any transfer cut short leaves memory untouched. The serial clock may pause for any length of time between edges. A protect register holds a boundary address and an active flag. Each programmed word is checked against that register before it is committed.

Top module: `ee_serial_front`

## Requirements
- R1: After reset, writes are disabled, the protect register reads inactive with boundary FFh, and `do_o` is 0. Write commands are refused until a write-enable command completes.
- R2: After chip select rises with the serial clock low, 0s sampled on rising serial clock edges are discarded. The first 1 sampled is the start bit.
- R3: A read (protect-enable low, opcode `10`, then 8 address bits, MSB first) drives a 0 first and then the 16-bit word MSB first. `do_o` changes after falling serial clock edges, so each bit is sampled on the next rising edge.
- R4: `do_o` is 0 whenever chip select is low.
- R5: A write (protect-enable low, opcode `01`) takes 16 data bits, MSB first, and is committed when chip select falls. It needs write-enable set and `wp_i` high at commit.
- R6: If chip select falls before the 16th data bit, or inside the header, memory is unchanged.
- R7: Write-enable (protect-enable low, opcode `00`, address bits 7:6 = `11`) and write-disable (opcode `00`, address bits 7:6 = `00`) take effect at the chip select fall whatever the level of `wp_i`.
- R8: A page write (protect-enable low, opcode `11`) accepts consecutive 16-bit words at addresses that increment and wrap from FFh to 00h. Each word is checked against protection on its own. A trailing partial word is dropped.
- R9: Write-all (protect-enable low, opcode `00`, address bits 7:6 = `01`) writes its 16-bit word to every address, but only while protection is inactive.
- R10: Protect read (protect-enable high, opcode `10`) drives a 0 first and then 9 bits, MSB first: an inactive flag (1 = protection off) followed by the 8-bit boundary.
- R11: Protect enable (protect-enable high, opcode `00`, address bits 7:6 = `11`) arms the protect register. Protect write (protect-enable high, opcode `01`) then loads the boundary from the address and activates protection. An unarmed protect write is ignored. While protection is active, writes to addresses at or above the boundary are refused.
- R12: Protect clear (protect-enable high, opcode `11`, address FFh) deactivates protection and sets the boundary to FFh.
- R13: Protect lock (protect-enable high, opcode `00`, address 00h) locks an armed protect register until reset. While locked, protect write and protect clear are ignored.
- R14: A command stays correct when the serial clock stops for a long time in the middle of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out, 0 while deselected |
| wp_i | input | 1 | Write permission pin, high allows programming |
| pe_i | input | 1 | Protect-enable pin, selects the protect command set |

## Verification
Reads and writes run through a table of address and data pairs. The number of leading 0s before the start bit differs from entry to entry, and the data values mix dense and sparse bit patterns. This separates start-bit hunting faults from bit-order faults. Separate runs repeat commands with `wp_i` low, without write-enable, cut short at several points, with a long serial clock pause, and across the address wrap. Each of these differs from a plain write in only one condition, so a refused or misplaced commit points to one gate. The protect sequence (unarmed write, armed write, writes below and above the boundary, clear, lock) tells apart the arm, lock and boundary comparison paths.

// File: rtl/ee_pkg.sv
package ee_pkg;

  typedef enum logic [2:0] {ST_IDLE, ST_HUNT, ST_HDR, ST_DATA, ST_READ, ST_SKIP} st_e;

  typedef enum logic [3:0] {
    C_NONE, C_READ, C_WRITE, C_PAGE, C_WRALL, C_WEN, C_WDS,
    C_PRREAD, C_PRWRITE, C_PRCLEAR, C_PREN, C_PRDS
  } cmd_e;

  // top: address bits 7:6, ones/zeros: whole address all 1 / all 0
  function automatic cmd_e ee_decode(input logic pe, input logic [1:0] op,
                                     input logic [1:0] top, input logic ones,
                                     input logic zeros);
    cmd_e c;
    c = C_NONE;
    if (!pe) begin
      case (op)
        2'b10: c = C_READ;
        2'b01: c = C_WRITE;
        2'b11: c = C_PAGE;
        default: begin
          case (top)
            2'b01:   c = C_WRALL;
            2'b11:   c = C_WEN;
            2'b00:   c = C_WDS;
            default: c = C_NONE;
          endcase
        end
      endcase
    end else begin
      case (op)
        2'b10: c = C_PRREAD;
        2'b01: c = C_PRWRITE;
        2'b11: c = ones ? C_PRCLEAR : C_NONE;
        default: begin
          if (top == 2'b11)  c = C_PREN;
          else if (zeros)    c = C_PRDS;
          else               c = C_NONE;
        end
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/ee_protect.sv
module ee_protect #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          lock_i,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] chk_addr_i,
  output logic          active_o,
  output logic [AW-1:0] bound_o,
  output logic          hit_o
);

  logic          armed_q, lock_q, active_q;
  logic [AW-1:0] bound_q;
  logic          open_w;

  assign open_w = armed_q && !lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      lock_q   <= 1'b0;
      active_q <= 1'b0;
      bound_q  <= '1;
    end else begin
      if (arm_i && !lock_q) armed_q <= 1'b1;
      if (lock_i && armed_q) lock_q <= 1'b1;
      if (set_i && open_w) begin
        bound_q  <= addr_i;
        active_q <= 1'b1;
      end else if (clr_i && open_w) begin
        bound_q  <= '1;
        active_q <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign bound_o  = bound_q;
  assign hit_o    = active_q && (chk_addr_i >= bound_q);

  p_lock_sticky_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  p_bound_guard_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bound_q) |-> $past(armed_q && !lock_q));

endmodule

// File: rtl/ee_array.sv
module ee_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          all_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else if (we_i && (all_i || waddr_i == AW'(g))) word_q <= wdata_i;
    end
    assign words[g] = word_q;
  end

  assign rdata_o = words[raddr_i];

endmodule

// File: rtl/ee_serial_front.sv
module ee_serial_front
  import ee_pkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int OPW = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  output logic do_o,
  input  logic wp_i,
  input  logic pe_i
);

  localparam int HDR_W = OPW + AW;
  localparam int MAXB  = (HDR_W > DW) ? HDR_W : DW;
  localparam int CNT_W = $clog2(MAXB + 1);

  st_e              st;
  cmd_e             cmd, cmd_dec;
  logic [CNT_W-1:0] cnt;
  logic [HDR_W-2:0] hdr_sr;
  logic [DW-2:0]    dsr;
  logic [HDR_W-1:0] hdr_full;
  logic [DW-1:0]    data_full, rdata;
  logic [AW-1:0]    dec_addr, cur_addr, pend_addr, bound;
  logic [OPW-1:0]   dec_op;
  logic [DW-1:0]    pend_data;
  logic [DW:0]      out_sr;
  logic             pend_v, do_q, wen_q, sclk_q, cs_q;
  logic             cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic             word_done, commit_ev, pgm_ok, mem_we, exec;
  logic             prot_active, prot_hit;

  assign cs_rise   = cs_i && !cs_q;
  assign cs_fall   = !cs_i && cs_q;
  assign sclk_rise = cs_i && sclk_i && !sclk_q;
  assign sclk_fall = cs_i && !sclk_i && sclk_q;

  assign hdr_full  = {hdr_sr, di_i};
  assign data_full = {dsr, di_i};
  assign dec_op    = hdr_full[HDR_W-1 -: OPW];
  assign dec_addr  = hdr_full[AW-1:0];
  assign cmd_dec   = ee_decode(pe_i, dec_op, dec_addr[AW-1 -: 2], &dec_addr, ~|dec_addr);

  assign word_done = (st == ST_DATA) && sclk_rise && (cnt == CNT_W'(DW - 1));
  assign commit_ev = pend_v && (cs_fall || word_done);
  assign pgm_ok    = wen_q && wp_i;
  assign mem_we    = commit_ev && pgm_ok &&
                     ((cmd == C_WRALL) ? !prot_active : !prot_hit);
  assign exec      = cs_fall && (st == ST_SKIP);

  ee_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i, .rst_ni,
    .we_i   (mem_we),
    .all_i  (cmd == C_WRALL),
    .waddr_i(pend_addr),
    .wdata_i(pend_data),
    .raddr_i(dec_addr),
    .rdata_o(rdata)
  );

  ee_protect #(.AW(AW)) u_protect (
    .clk_i, .rst_ni,
    .arm_i     (exec && cmd == C_PREN && pgm_ok),
    .lock_i    (exec && cmd == C_PRDS && pgm_ok),
    .set_i     (exec && cmd == C_PRWRITE && pgm_ok),
    .clr_i     (exec && cmd == C_PRCLEAR && pgm_ok),
    .addr_i    (cur_addr),
    .chk_addr_i(pend_addr),
    .active_o  (prot_active),
    .bound_o   (bound),
    .hit_o     (prot_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; cmd <= C_NONE; cnt <= '0;
      hdr_sr <= '0; dsr <= '0; out_sr <= '0;
      cur_addr <= '0; pend_addr <= '0; pend_data <= '0;
      pend_v <= 1'b0; do_q <= 1'b0; wen_q <= 1'b0;
      sclk_q <= 1'b0; cs_q <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_i;
      if (exec && cmd == C_WEN) wen_q <= 1'b1;
      if (exec && cmd == C_WDS) wen_q <= 1'b0;
      if (commit_ev) pend_v <= 1'b0;
      if (!cs_i) begin
        st   <= ST_IDLE;
        do_q <= 1'b0;
      end else if (cs_rise) begin
        st     <= ST_HUNT;
        cnt    <= '0;
        do_q   <= 1'b0;
        pend_v <= 1'b0;
      end else begin
        case (st)
          ST_HUNT: if (sclk_rise && di_i) begin
            st  <= ST_HDR;
            cnt <= '0;
          end
          ST_HDR: if (sclk_rise) begin
            hdr_sr <= hdr_full[HDR_W-2:0];
            cnt    <= cnt + 1'b1;
            if (cnt == CNT_W'(HDR_W - 1)) begin
              cnt      <= '0;
              cmd      <= cmd_dec;
              cur_addr <= dec_addr;
              case (cmd_dec)
                C_READ:   begin out_sr <= {1'b0, rdata}; st <= ST_READ; end
                C_PRREAD: begin
                  out_sr <= {1'b0, !prot_active, bound, {(DW - AW - 1){1'b0}}};
                  st     <= ST_READ;
                end
                C_WRITE, C_PAGE, C_WRALL: st <= ST_DATA;
                default: st <= ST_SKIP;
              endcase
            end
          end
          ST_DATA: if (sclk_rise) begin
            dsr <= data_full[DW-2:0];
            cnt <= cnt + 1'b1;
            if (word_done) begin
              cnt       <= '0;
              pend_v    <= 1'b1;
              pend_addr <= cur_addr;
              pend_data <= data_full;
              cur_addr  <= cur_addr + AW'(1);
              if (cmd != C_PAGE) st <= ST_SKIP;
            end
          end
          ST_READ: if (sclk_fall) begin
            do_q   <= out_sr[DW];
            out_sr <= {out_sr[DW-1:0], 1'b0};
          end
          default: ;
        endcase
      end
    end
  end

  assign do_o = cs_i && do_q;

  p_start_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st == ST_HDR) |-> $past(di_i));

  p_do_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(do_q) |-> $past(sclk_fall || !cs_i || cs_rise));

  p_wen_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wen_q) |-> $past(cs_fall));

  p_hdr_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_HDR) |-> (cnt < CNT_W'(HDR_W)));

endmodule

// File: tb/tb_ee_serial_front.sv
module tb_ee_serial_front;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, di = 1'b0, wp = 1'b1, pe = 1'b0;
  logic do_w;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  ee_serial_front dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .sclk_i(sclk),
    .di_i(di), .do_o(do_w), .wp_i(wp), .pe_i(pe)
  );

  // {leading zeros, address, data}
  localparam logic [27:0] VEC [6] = '{
    {4'd0, 8'h20, 16'hA001}, {4'd1, 8'h21, 16'h5AC3},
    {4'd3, 8'h3C, 16'hFFFF}, {4'd2, 8'h55, 16'h0001},
    {4'd5, 8'h6A, 16'h8000}, {4'd0, 8'h7E, 16'h1234}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    di = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic hdr(input logic p, input logic [1:0] op, input logic [7:0] a, input int nz);
    pe = p;
    cs = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nz; i++) sbit(1'b0);
    sbit(1'b1);
    send({14'd0, op}, 2);
    send({8'd0, a}, 8);
  endtask

  task automatic fin;
    cs = 1'b0;
    di = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmd0(input logic p, input logic [1:0] op, input logic [7:0] a);
    hdr(p, op, a, 0);
    fin();
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input int nz);
    hdr(1'b0, 2'b01, a, nz);
    send(d, 16);
    fin();
  endtask

  task automatic rd(input logic p, input logic [7:0] a, input int nz, output logic [16:0] v);
    hdr(p, 2'b10, a, nz);
    for (int i = 16; i >= 0; i--) begin
      v[i] = do_w;
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    fin();
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R14 watchdog actual=timeout expected=finished");
      report();
    end
  end

  initial begin
    logic [16:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    chk("R1 do_o after reset", {31'd0, do_w}, 32'd0);
    rd(1'b1, 8'h00, 0, v);
    chk("R10 protect read after reset", {23'd0, v[15:7]}, 32'h1FF);
    chk("R10 protect dummy", {31'd0, v[16]}, 32'd0);

    wr(8'h05, 16'h1234, 0);
    rd(1'b0, 8'h05, 0, v);
    chk("R1 write refused before enable", {15'd0, v}, 32'd0);

    wp = 1'b0;
    cmd0(1'b0, 2'b00, 8'hC0);
    wp = 1'b1;
    wr(8'h05, 16'h1234, 0);
    rd(1'b0, 8'h05, 0, v);
    chk("R7 enable ignores wp, R5 write", {15'd0, v}, 32'h1234);
    chk("R4 do_o low after deselect", {31'd0, do_w}, 32'd0);

    wp = 1'b0;
    wr(8'h06, 16'hBEEF, 0);
    wp = 1'b1;
    rd(1'b0, 8'h06, 0, v);
    chk("R5 write refused with wp low", {15'd0, v}, 32'd0);

    foreach (VEC[k]) begin
      wr(VEC[k][23:16], VEC[k][15:0], int'(VEC[k][27:24]));
      rd(1'b0, VEC[k][23:16], int'(VEC[k][27:24]), v);
      chk("R2 R3 R5 table readback", {15'd0, v}, {16'd0, VEC[k][15:0]});
    end

    hdr(1'b0, 2'b01, 8'h07, 0);
    send(16'h02AB, 10);
    fin();
    rd(1'b0, 8'h07, 0, v);
    chk("R6 abort in data", {15'd0, v}, 32'd0);
    hdr(1'b0, 2'b01, 8'h05, 0);
    fin();
    pe = 1'b0;
    cs = 1'b1;
    repeat (2) @(negedge clk);
    sbit(1'b1);
    send(16'h0015, 5);
    fin();
    rd(1'b0, 8'h05, 0, v);
    chk("R6 abort in header", {15'd0, v}, 32'h1234);

    pe = 1'b0;
    cs = 1'b1;
    repeat (2) @(negedge clk);
    sbit(1'b1);
    send(16'h0001, 2);
    repeat (1000) @(negedge clk);
    send(16'h0008, 8);
    send(16'hCAFE, 16);
    fin();
    rd(1'b0, 8'h08, 0, v);
    chk("R14 stopped clock write", {15'd0, v}, 32'hCAFE);

    hdr(1'b0, 2'b11, 8'hFE, 0);
    send(16'h1111, 16);
    send(16'h2222, 16);
    send(16'h3333, 16);
    send(16'h0055, 7);
    fin();
    rd(1'b0, 8'hFE, 0, v);
    chk("R8 page word 0", {15'd0, v}, 32'h1111);
    rd(1'b0, 8'hFF, 0, v);
    chk("R8 page word 1", {15'd0, v}, 32'h2222);
    rd(1'b0, 8'h00, 0, v);
    chk("R8 page wrap", {15'd0, v}, 32'h3333);
    rd(1'b0, 8'h01, 0, v);
    chk("R8 partial word dropped", {15'd0, v}, 32'd0);

    hdr(1'b0, 2'b00, 8'h40, 0);
    send(16'h5A5A, 16);
    fin();
    rd(1'b0, 8'h20, 0, v);
    chk("R9 write all low", {15'd0, v}, 32'h5A5A);
    rd(1'b0, 8'h99, 0, v);
    chk("R9 write all high", {15'd0, v}, 32'h5A5A);

    cmd0(1'b1, 2'b01, 8'h80);
    rd(1'b1, 8'h00, 0, v);
    chk("R11 unarmed protect write ignored", {23'd0, v[15:7]}, 32'h1FF);
    cmd0(1'b1, 2'b00, 8'hC0);
    cmd0(1'b1, 2'b01, 8'h80);
    rd(1'b1, 8'h00, 0, v);
    chk("R11 protect write", {23'd0, v[15:7]}, 32'h080);
    wr(8'h90, 16'h1357, 0);
    rd(1'b0, 8'h90, 0, v);
    chk("R11 write above boundary refused", {15'd0, v}, 32'h5A5A);
    wr(8'h10, 16'h2468, 0);
    rd(1'b0, 8'h10, 0, v);
    chk("R11 write below boundary", {15'd0, v}, 32'h2468);

    hdr(1'b0, 2'b11, 8'h7F, 0);
    send(16'h7777, 16);
    send(16'h8888, 16);
    fin();
    rd(1'b0, 8'h7F, 0, v);
    chk("R8 page below boundary", {15'd0, v}, 32'h7777);
    rd(1'b0, 8'h80, 0, v);
    chk("R8 page word at boundary refused", {15'd0, v}, 32'h5A5A);

    hdr(1'b0, 2'b00, 8'h40, 0);
    send(16'h0000, 16);
    fin();
    rd(1'b0, 8'h10, 0, v);
    chk("R9 write all refused while protected", {15'd0, v}, 32'h2468);

    cmd0(1'b1, 2'b11, 8'hFF);
    rd(1'b1, 8'h00, 0, v);
    chk("R12 protect clear", {23'd0, v[15:7]}, 32'h1FF);
    wr(8'h90, 16'h1357, 0);
    rd(1'b0, 8'h90, 0, v);
    chk("R12 write after clear", {15'd0, v}, 32'h1357);

    cmd0(1'b1, 2'b00, 8'h00);
    cmd0(1'b1, 2'b01, 8'h40);
    rd(1'b1, 8'h00, 0, v);
    chk("R13 locked protect write ignored", {23'd0, v[15:7]}, 32'h1FF);

    wp = 1'b0;
    cmd0(1'b0, 2'b00, 8'h00);
    wp = 1'b1;
    wr(8'h11, 16'h9999, 0);
    rd(1'b0, 8'h11, 0, v);
    chk("R7 disable ignores wp", {15'd0, v}, 32'h5A5A);

    done = 1'b1;
    report();
  end

endmodule